// File: doc/BRIEF.md
# Patch Energy Summer with Three-Level Classification

This block is one stage of a pipelined first-level trigger. Each cycle it can take a group of calorimeter patch energies, every one an unsigned 10-bit value. It forms the full-precision sum of the group. It also grades every patch against three programmable energy levels. The sum and the per-patch grades leave together, one clock later, in a single packed word with a valid flag.

The three levels are loaded through a small write-enable register port. A select field picks which level is written. The core assumes that software keeps the levels in ascending order.

The group size is a parameter and can be six, four or two patches. The sum field is 14 bits wide for six or four patches and 13 bits wide for two.

Top module: `patch_sum_classifier`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `out_word` is 0 and all three levels hold 1023, so a patch of 1023 grades 3 and any lower patch grades 0.
- R2: `out_valid` in a cycle equals `in_valid` of the cycle before, so results have exactly one cycle of latency.
- R3: Bits [SUM_W-1:0] of `out_word` hold the exact sum of all patch energies of the accepted group. SUM_W is 14 for six or four patches and 13 for two, and the largest sum (all patches 1023) does not overflow.
- R4: A patch grades 0 when it is below the low level, 1 when it is at or above low but below mid, 2 when it is at or above mid but below high, and 3 when it is at or above high. Every comparison is greater-than-or-equal.
- R5: The 2-bit grade of patch i (patch i is `in_energy[10*i+9:10*i]`) sits at `out_word[SUM_W+2i+1:SUM_W+2i]`, so the lowest-numbered patch is directly above the sum field.
- R6: A write with `cfg_we`=1 loads `cfg_data` into the low level (`cfg_sel`=0), the mid level (1) or the high level (2). A group accepted in the same cycle as the write still uses the old value, and groups in later cycles use the new one.
- R7: A write with `cfg_sel`=3 changes no level.
- R8: While `in_valid` is 0, `out_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group is valid this cycle |
| in_energy | input | NUM_PATCH*10 | Packed patch energies, patch 0 in the low bits |
| cfg_we | input | 1 | Level write enable |
| cfg_sel | input | 2 | Level select: 0 low, 1 mid, 2 high, 3 none |
| cfg_data | input | 10 | Level value to write |
| out_valid | output | 1 | Output word is valid |
| out_word | output | SUM_W+2*NUM_PATCH | Packed grades above the group sum |

## Verification
The bench runs four kinds of input. Groups placed exactly on each level and one count below it show whether every comparison is greater-than-or-equal. Groups of all zeros and all 1023 show whether the sum field is truncated or overflows. Long runs of random energies with random gaps in `in_valid` show whether the output holds between groups and whether the latency is right. Level writes that land in the same cycle as a group, and writes with the unused select value, show whether the write timing and the ignored select behave as required.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int ENERGY_W = 10;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_NONE = 2'd3
  } lvl_sel_e;
endpackage

// File: rtl/psc_level_regs.sv
module psc_level_regs #(
  parameter int E_W = psc_pkg::ENERGY_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [E_W-1:0] cfg_data,
  output logic [E_W-1:0] lvl_low,
  output logic [E_W-1:0] lvl_mid,
  output logic [E_W-1:0] lvl_high
);
  import psc_pkg::*;
  localparam logic [E_W-1:0] LVL_RESET = '1;

  lvl_sel_e sel;
  assign sel = lvl_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_low  <= LVL_RESET;
      lvl_mid  <= LVL_RESET;
      lvl_high <= LVL_RESET;
    end else if (cfg_we) begin
      case (sel)
        LVL_LOW:  lvl_low  <= cfg_data;
        LVL_MID:  lvl_mid  <= cfg_data;
        LVL_HIGH: lvl_high <= cfg_data;
        default:  ;
      endcase
    end
  end

  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd0) |=> lvl_low == $past(cfg_data)); // R6
  AST_HIGH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd2) |=> lvl_high == $past(cfg_data)); // R6
  AST_SEL_NONE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd3) |=> ($stable(lvl_low) && $stable(lvl_mid) && $stable(lvl_high))); // R7
endmodule

// File: rtl/psc_grade.sv
module psc_grade #(
  parameter int E_W = psc_pkg::ENERGY_W
) (
  input  logic [E_W-1:0] energy,
  input  logic [E_W-1:0] lvl_low,
  input  logic [E_W-1:0] lvl_mid,
  input  logic [E_W-1:0] lvl_high,
  output logic [1:0]     grade
);
  always_comb begin
    if (energy >= lvl_high)      grade = 2'd3;
    else if (energy >= lvl_mid)  grade = 2'd2;
    else if (energy >= lvl_low)  grade = 2'd1;
    else                         grade = 2'd0;
  end
endmodule

// File: rtl/psc_adder.sv
module psc_adder #(
  parameter int N     = 6,
  parameter int E_W   = psc_pkg::ENERGY_W,
  parameter int SUM_W = 14
) (
  input  logic [N*E_W-1:0] energies,
  output logic [SUM_W-1:0] sum
);
  localparam int PAD_W = SUM_W - E_W;

  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) begin
      sum = sum + {{PAD_W{1'b0}}, energies[i*E_W +: E_W]};
    end
  end
endmodule

// File: rtl/patch_sum_classifier.sv
module patch_sum_classifier #(
  parameter int NUM_PATCH = 6,
  parameter int E_W       = psc_pkg::ENERGY_W
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         in_valid,
  input  logic [NUM_PATCH*E_W-1:0]                     in_energy,
  input  logic                                         cfg_we,
  input  logic [1:0]                                   cfg_sel,
  input  logic [E_W-1:0]                               cfg_data,
  output logic                                         out_valid,
  output logic [((NUM_PATCH > 2) ? 14 : 13)+2*NUM_PATCH-1:0] out_word
);
  localparam int SUM_W   = (NUM_PATCH > 2) ? 14 : 13;
  localparam int GRADE_W = 2 * NUM_PATCH;
  localparam int OUT_W   = SUM_W + GRADE_W;

  logic [E_W-1:0]     lvl_low, lvl_mid, lvl_high;
  logic [SUM_W-1:0]   sum_c;
  logic [GRADE_W-1:0] grades_c;

  psc_level_regs #(.E_W(E_W)) u_levels (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .lvl_low  (lvl_low),
    .lvl_mid  (lvl_mid),
    .lvl_high (lvl_high)
  );

  psc_adder #(.N(NUM_PATCH), .E_W(E_W), .SUM_W(SUM_W)) u_adder (
    .energies (in_energy),
    .sum      (sum_c)
  );

  for (genvar g = 0; g < NUM_PATCH; g++) begin : g_grade
    psc_grade #(.E_W(E_W)) u_grade (
      .energy   (in_energy[g*E_W +: E_W]),
      .lvl_low  (lvl_low),
      .lvl_mid  (lvl_mid),
      .lvl_high (lvl_high),
      .grade    (grades_c[2*g +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= {grades_c, sum_c};
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[SUM_W-1:0] >= {{(SUM_W-E_W){1'b0}}, $past(in_energy[E_W-1:0])}); // R3
  AST_WIDTH_OK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> OUT_W == $bits(out_word)); // R5
endmodule

// File: tb/patch_sum_classifier_tb_top.sv
module patch_sum_classifier_tb_top;
  localparam int NP    = 6;
  localparam int EW    = 10;
  localparam int SUM_W = 14;
  localparam int OUT_W = SUM_W + 2*NP;

  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [NP*EW-1:0] in_energy = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [EW-1:0] cfg_data = 0;
  logic out_valid;
  logic [OUT_W-1:0] out_word;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit compare_on = 0;

  int lv[3];
  bit exp_valid;
  logic [OUT_W-1:0] exp_word;

  always #2.5 clk = ~clk;

  patch_sum_classifier #(.NUM_PATCH(NP), .E_W(EW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_energy(in_energy),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [OUT_W-1:0] model(logic [NP*EW-1:0] e);
    int s = 0;
    logic [OUT_W-1:0] w = '0;
    for (int i = 0; i < NP; i++) begin
      int v = int'(e[i*EW +: EW]);
      int g = (v >= lv[2]) ? 3 : (v >= lv[1]) ? 2 : (v >= lv[0]) ? 1 : 0;
      s += v;
      w[SUM_W + 2*i +: 2] = 2'(g);
    end
    w[SUM_W-1:0] = SUM_W'(s);
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_valid = 0;
      exp_word = '0;
      for (int k = 0; k < 3; k++) lv[k] = 1023;
    end else begin
      exp_valid = in_valid;
      if (in_valid) exp_word = model(in_energy);
      if (cfg_we && cfg_sel != 2'd3) lv[cfg_sel] = int'(cfg_data);
    end
  end

  task automatic check(string req, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      check({cur_req, " valid"}, OUT_W'(out_valid), OUT_W'(exp_valid));
      check({cur_req, " word"}, out_word, exp_word);
    end
  end

  task automatic send(input logic [NP*EW-1:0] e);
    @(negedge clk);
    in_valid = 1; in_energy = e;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [EW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [NP*EW-1:0] pack6(int a, int b, int c, int d, int e, int f);
    return {EW'(f), EW'(e), EW'(d), EW'(c), EW'(b), EW'(a)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", OUT_W'(out_valid), '0);
    check("R1 reset word", out_word, '0);
    rst = 0;
    compare_on = 1;
    // R1: reset levels at 1023
    cur_req = "R1";
    send(pack6(1023, 1022, 0, 1023, 500, 1));
    @(negedge clk);
    check("R1 explicit grades", out_word,
          {2'd0, 2'd0, 2'd3, 2'd0, 2'd0, 2'd3, 14'd3569});

    // R6: program levels
    cur_req = "R6";
    wr(2'd0, 10'd100);
    wr(2'd1, 10'd300);
    wr(2'd2, 10'd700);
    // R4 / R5: boundary values, each patch a distinct grade position
    cur_req = "R4";
    send(pack6(99, 100, 299, 300, 699, 700));
    @(negedge clk);
    check("R4 R5 explicit", out_word,
          {2'd3, 2'd2, 2'd2, 2'd1, 2'd1, 2'd0, 14'd2197});
    cur_req = "R5";
    send(pack6(700, 0, 0, 0, 0, 0));
    send(pack6(0, 0, 0, 0, 0, 300));
    // R3: extremes
    cur_req = "R3";
    send(pack6(0, 0, 0, 0, 0, 0));
    send(pack6(1023, 1023, 1023, 1023, 1023, 1023));
    @(negedge clk);
    check("R3 max sum", {18'd0, out_word[SUM_W-1:0]}, OUT_W'(6138));
    // R7: ignored select
    cur_req = "R7";
    wr(2'd3, 10'd0);
    send(pack6(99, 99, 99, 99, 99, 99));
    @(negedge clk);
    check("R7 grades unchanged", out_word[OUT_W-1:SUM_W], '0);
    // R6: write in same cycle as a group
    cur_req = "R6";
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd0; cfg_data = 10'd50;
    in_valid = 1; in_energy = pack6(60, 60, 60, 60, 60, 60);
    @(negedge clk);
    cfg_we = 0;
    check("R6 old level used", out_word[OUT_W-1:SUM_W], '0);
    @(negedge clk);
    in_valid = 0;
    check("R6 new level used", out_word[OUT_W-1:SUM_W], OUT_W'(12'h555) >> 0);
    // R2 / R8: random groups with gaps
    cur_req = "R2 R8";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 2) != 0);
      for (int p = 0; p < NP; p++) in_energy[p*EW +: EW] = EW'($urandom_range(0, 1023));
      if ($urandom_range(0, 15) == 0) begin
        cfg_we = 1; cfg_sel = 2'($urandom_range(0, 3)); cfg_data = EW'($urandom_range(0, 1023));
      end else cfg_we = 0;
    end
    @(negedge clk);
    in_valid = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule